// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive byte stream of an Ethernet MAC. It watches the first six bytes of every frame, which hold the destination address, and decides whether the frame is wanted. A frame is wanted if promiscuous reception is on, if its address equals the programmed station address, if it is the all-ones broadcast address, or if it lands on a set bit of a 64-entry multicast hash table. Nothing passes while reception is disabled.

The stream arrives one byte per cycle with a start-of-frame marker on the first byte. A reflected CRC-32 runs over the address bytes as they arrive, and the byte compares accumulate alongside it. One cycle after the sixth byte the block raises a one-cycle decision pulse that carries the accept or reject verdict. Frame storage, descriptor handling and checksums belong to other blocks.

Top module: `rx_dest_filter`

## Requirements
- R1: When `cfg_rx_en` is 0 at the sixth address byte, the decision is reject regardless of any other setting.
- R2: With `cfg_rx_en` 1 and `cfg_promisc` 1, the decision is accept for any destination.
- R3: `cfg_station` holds three 16-bit words, word k in bits [16k+15:16k]; word k supplies address bytes 2k (its upper byte) and 2k+1 (its lower byte). An exact match accepts; any byte mismatch or swapped byte order does not match.
- R4: A destination of six 0xFF bytes is accepted as broadcast when reception is enabled.
- R5: The hash index is bits [31:26] of a CRC-32 over the six address bytes, polynomial 0xEDB88320, each byte taken LSB first, seed 0xFFFFFFFF, no final inversion.
- R6: With `cfg_hash_en` 1, index bits [5:4] select hash word k held in `cfg_hash` bits [16k+15:16k], index bits [3:0] select the bit in it; a set bit accepts.
- R7: A destination matching neither station nor broadcast is rejected when hashing is disabled or its hash bit is 0.
- R8: `dec_valid` is high for exactly one cycle, the cycle after the sixth byte of a frame is taken; bytes after the sixth produce no further decision.
- R9: `in_sof` on a valid byte restarts the address capture, CRC and compares; a frame cut off before six bytes produces no decision.
- R10: The configuration inputs are sampled in the cycle the sixth byte is taken; earlier or later values do not affect the verdict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_promisc | input | 1 | Accept all frames |
| cfg_hash_en | input | 1 | Enable multicast hash lookup |
| cfg_station | input | 48 | Station address, three 16-bit words |
| cfg_hash | input | 64 | Hash table, four 16-bit words |
| in_valid | input | 1 | Byte present on `in_data` |
| in_sof | input | 1 | Byte is the first of a frame |
| in_data | input | 8 | Received byte |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Verdict, meaningful while `dec_valid` is 1 |

## Verification
The decision pulse of one frame and the first byte of the next can share a cycle when frames are packed back to back. The bench drives the start-of-frame byte of a second frame on exactly the cycle the first frame's verdict is sampled, with one frame accepted and the other rejected in both orders, and checks both verdicts. A wrong verdict for the second frame shows that its CRC or compare state was not reseeded while the previous result was still on the outputs.

// File: rtl/rdf_pkg.sv
package rdf_pkg;
    localparam int unsigned CRC_W      = 32;
    localparam logic [31:0] CRC_POLY   = 32'hEDB8_8320;
    localparam logic [31:0] CRC_SEED   = 32'hFFFF_FFFF;
    localparam int unsigned BYTE_W     = 8;
endpackage

// File: rtl/rdf_crc_byte.sv
module rdf_crc_byte
    import rdf_pkg::*;
#(
    parameter int unsigned W = CRC_W,
    parameter logic [W-1:0] POLY = CRC_POLY
) (
    input  logic [W-1:0]      crc_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [W-1:0]      crc_o
);
    logic [W-1:0] stage [0:BYTE_W];

    assign stage[0] = crc_i;

    // One reflected shift per data bit, least significant bit first.
    for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
        assign stage[b+1] = {1'b0, stage[b][W-1:1]}
                          ^ ((stage[b][0] ^ byte_i[b]) ? POLY : '0);
    end

    assign crc_o = stage[BYTE_W];
endmodule

// File: rtl/rdf_addr_cmp.sv
module rdf_addr_cmp
    import rdf_pkg::*;
#(
    parameter int unsigned N_WORDS = 3,
    parameter int unsigned WORD_W  = 16,
    parameter int unsigned POS_W   = 3
) (
    input  logic [N_WORDS*WORD_W-1:0] station,
    input  logic [POS_W-1:0]          pos,
    input  logic [BYTE_W-1:0]         data,
    output logic                      stn_hit,
    output logic                      ones_hit
);
    logic [BYTE_W-1:0] want;

    // Even positions take the upper byte of a word, odd ones the lower byte.
    always_comb begin
        want = '0;
        for (int k = 0; k < N_WORDS; k++) begin
            if (pos == POS_W'(2*k))
                want = station[k*WORD_W+BYTE_W +: BYTE_W];
            else if (pos == POS_W'(2*k+1))
                want = station[k*WORD_W +: BYTE_W];
        end
    end

    assign stn_hit  = (data == want);
    assign ones_hit = (data == {BYTE_W{1'b1}});
endmodule

// File: rtl/rdf_hash_pick.sv
module rdf_hash_pick #(
    parameter int unsigned N_WORDS = 4,
    parameter int unsigned WORD_W  = 16,
    parameter int unsigned IDX_W   = 6
) (
    input  logic [N_WORDS*WORD_W-1:0] table_bits,
    input  logic [IDX_W-1:0]          idx,
    output logic                      hit
);
    localparam int unsigned BIT_W = $clog2(WORD_W);
    localparam int unsigned SEL_W = IDX_W - BIT_W;

    logic [WORD_W-1:0] word;

    always_comb begin
        word = '0;
        for (int k = 0; k < N_WORDS; k++) begin
            if (idx[IDX_W-1:BIT_W] == SEL_W'(k))
                word = table_bits[k*WORD_W +: WORD_W];
        end
    end

    assign hit = word[idx[BIT_W-1:0]];
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
    import rdf_pkg::*;
#(
    parameter int unsigned WORD_W     = 16,
    parameter int unsigned STN_WORDS  = 3,
    parameter int unsigned HASH_WORDS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_rx_en,
    input  logic                         cfg_promisc,
    input  logic                         cfg_hash_en,
    input  logic [STN_WORDS*WORD_W-1:0]  cfg_station,
    input  logic [HASH_WORDS*WORD_W-1:0] cfg_hash,
    input  logic                         in_valid,
    input  logic                         in_sof,
    input  logic [BYTE_W-1:0]            in_data,
    output logic                         dec_valid,
    output logic                         dec_accept
);
    localparam int unsigned ADDR_BYTES = STN_WORDS * WORD_W / BYTE_W;
    localparam int unsigned POS_W      = $clog2(ADDR_BYTES + 1);
    localparam int unsigned IDX_W      = $clog2(HASH_WORDS * WORD_W);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(ADDR_BYTES - 1);

    typedef struct packed {
        logic [POS_W-1:0] cnt;
        logic             active;
        logic [CRC_W-1:0] crc;
        logic             exact;
        logic             ones;
        logic             dvalid;
        logic             daccept;
    } state_t;

    state_t state_d, state_q;

    logic             take;
    logic [POS_W-1:0] pos;
    logic [CRC_W-1:0] crc_in, crc_next;
    logic             stn_hit, ones_hit, hash_hit;
    logic             exact_run, ones_run, decide_now, verdict;

    assign take   = in_valid && (in_sof || state_q.active);
    assign pos    = in_sof ? '0 : state_q.cnt;
    assign crc_in = in_sof ? CRC_SEED : state_q.crc;

    rdf_crc_byte #(.W(CRC_W), .POLY(CRC_POLY)) i_crc (
        .crc_i  (crc_in),
        .byte_i (in_data),
        .crc_o  (crc_next)
    );

    rdf_addr_cmp #(.N_WORDS(STN_WORDS), .WORD_W(WORD_W), .POS_W(POS_W)) i_cmp (
        .station  (cfg_station),
        .pos      (pos),
        .data     (in_data),
        .stn_hit  (stn_hit),
        .ones_hit (ones_hit)
    );

    rdf_hash_pick #(.N_WORDS(HASH_WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W)) i_hash (
        .table_bits (cfg_hash),
        .idx        (crc_next[CRC_W-1 -: IDX_W]),
        .hit        (hash_hit)
    );

    assign exact_run  = (in_sof || state_q.exact) && stn_hit;
    assign ones_run   = (in_sof || state_q.ones) && ones_hit;
    assign decide_now = take && (pos == LAST_POS);
    assign verdict    = cfg_rx_en && (cfg_promisc || exact_run || ones_run
                                      || (cfg_hash_en && hash_hit));

    always_comb begin
        state_d         = state_q;
        state_d.dvalid  = 1'b0;
        state_d.daccept = 1'b0;
        if (take) begin
            state_d.cnt    = pos + POS_W'(1);
            state_d.active = (pos != LAST_POS);
            state_d.crc    = crc_next;
            state_d.exact  = exact_run;
            state_d.ones   = ones_run;
            if (pos == LAST_POS) begin
                state_d.dvalid  = 1'b1;
                state_d.daccept = verdict;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q        <= '0;
            state_q.crc    <= CRC_SEED;
        end else begin
            state_q <= state_d;
        end
    end

    assign dec_valid  = state_q.dvalid;
    assign dec_accept = state_q.daccept;

    p_off_rejects_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (decide_now && !cfg_rx_en) |=> (dec_valid && !dec_accept));

    p_promisc_accepts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (decide_now && cfg_rx_en && cfg_promisc) |=> (dec_valid && dec_accept));

    p_bcast_accepts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (decide_now && cfg_rx_en && ones_run) |=> dec_accept);

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    p_sof_no_decision_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |=> !dec_valid);
endmodule

// File: tb/test_rx_dest_filter.sv
`timescale 1ns/1ps
module test_rx_dest_filter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_rx_en, cfg_promisc, cfg_hash_en;
    logic [47:0] cfg_station;
    logic [63:0] cfg_hash;
    logic        in_valid, in_sof;
    logic [7:0]  in_data;
    logic        dec_valid, dec_accept;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    rx_dest_filter i_rx_dest_filter (
        .clk(clk), .rst_n(rst_n),
        .cfg_rx_en(cfg_rx_en), .cfg_promisc(cfg_promisc), .cfg_hash_en(cfg_hash_en),
        .cfg_station(cfg_station), .cfg_hash(cfg_hash),
        .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
        .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    localparam logic [47:0] STN   = 48'h0A1B_2C3D_4E5F;
    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] OTHER = 48'h0200_1122_3344;

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [47:0] d);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            logic [7:0] b = d[47-8*i -: 8];
            for (int k = 0; k < 8; k++) begin
                logic fb = c[0] ^ b[k];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB8_8320;
            end
        end
        return c;
    endfunction

    function automatic logic [5:0] ref_idx(input logic [47:0] d);
        logic [31:0] c = ref_crc(d);
        return c[31:26];
    endfunction

    task automatic drive(input logic sof, input logic [7:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_sof = sof; in_data = d;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
    endtask

    // Six address bytes, verdict sampled one cycle after the sixth, then extra payload.
    task automatic run_frame(input logic [47:0] dst, input int extra,
                             output logic v, output logic a);
        for (int i = 0; i < 6; i++) drive(i == 0, dst[47-8*i -: 8]);
        @(negedge clk);
        v = dec_valid; a = dec_accept;
        in_valid = (extra > 0); in_sof = 1'b0; in_data = 8'h55;
        for (int e = 0; e < extra; e++) begin
            @(negedge clk);
            chk("R8", "no pulse during payload", dec_valid, 1'b0);
            if (e == extra - 1) in_valid = 1'b0;
        end
        idle();
    endtask

    task automatic expect_frame(input string req, input string what,
                                input logic [47:0] dst, input logic exp);
        logic v, a;
        run_frame(dst, 0, v, a);
        chk(req, {what, " valid"}, v, 1'b1);
        chk(req, what, a, exp);
    endtask

    task automatic set_cfg(input logic en, input logic pm, input logic he);
        cfg_rx_en = en; cfg_promisc = pm; cfg_hash_en = he;
    endtask

    task automatic t_disabled();
        set_cfg(1'b0, 1'b1, 1'b1);
        cfg_hash = '1;
        expect_frame("R1", "disabled broadcast+promisc", BCAST, 1'b0);
        expect_frame("R1", "disabled station", STN, 1'b0);
    endtask

    task automatic t_promisc();
        set_cfg(1'b1, 1'b1, 1'b0);
        cfg_hash = '0;
        expect_frame("R2", "promisc other", OTHER, 1'b1);
    endtask

    task automatic t_exact();
        set_cfg(1'b1, 1'b0, 1'b0);
        expect_frame("R3", "station exact", STN, 1'b1);
        expect_frame("R3", "station byte swap", 48'h1B0A_2C3D_4E5F, 1'b0);
        expect_frame("R3", "station last byte", 48'h0A1B_2C3D_4E5E, 1'b0);
        expect_frame("R3", "word order", 48'h4E5F_2C3D_0A1B, 1'b0);
    endtask

    task automatic t_bcast();
        set_cfg(1'b1, 1'b0, 1'b0);
        expect_frame("R4", "broadcast", BCAST, 1'b1);
        expect_frame("R7", "near broadcast", 48'hFFFF_FFFF_FFFE, 1'b0);
    endtask

    task automatic t_hash();
        for (int k = 0; k < 4; k++) begin
            logic [47:0] d = {40'h01_005E_0000, 8'(k * 37 + 1)};
            logic [5:0]  ix = ref_idx(d);
            set_cfg(1'b1, 1'b0, 1'b1);
            cfg_hash = 64'd1 << ix;
            expect_frame("R5", "hash single bit", d, 1'b1);
            cfg_hash = {16'h0, 16'h0, 16'h0, 16'h0};
            cfg_hash[{ix[5:4], 4'h0} + {2'b0, ix[3:0]}] = 1'b1;
            expect_frame("R6", "hash word/bit select", d, 1'b1);
            cfg_hash = ~(64'd1 << ix);
            expect_frame("R7", "hash bit clear", d, 1'b0);
            cfg_hash = '1;
            set_cfg(1'b1, 1'b0, 1'b0);
            expect_frame("R7", "hash disabled", d, 1'b0);
        end
    endtask

    task automatic t_trailing();
        logic v, a;
        set_cfg(1'b1, 1'b0, 1'b0);
        run_frame(BCAST, 12, v, a);
        chk("R8", "long frame valid", v, 1'b1);
        chk("R8", "long frame accept", a, 1'b1);
        @(negedge clk);
        chk("R8", "idle after frame", dec_valid, 1'b0);
    endtask

    task automatic t_short();
        logic [47:0] d = 48'h01_005E_0000_07;
        logic v, a;
        set_cfg(1'b1, 1'b0, 1'b1);
        cfg_hash = 64'd1 << ref_idx(d);
        for (int i = 0; i < 3; i++) begin
            drive(i == 0, 8'hFF);
            @(posedge clk); #1;
            chk("R9", "no pulse in short frame", dec_valid, 1'b0);
        end
        expect_frame("R9", "after short broadcast", OTHER, 1'b0);
        for (int i = 0; i < 5; i++) drive(i == 0, 8'hA5 + 8'(i));
        run_frame(d, 0, v, a);
        chk("R9", "hash after 5-byte stub valid", v, 1'b1);
        chk("R9", "hash after 5-byte stub", a, 1'b1);
    endtask

    // Start of the next frame lands in the verdict cycle of the previous one.
    task automatic t_overlap(input logic [47:0] da, input logic ea,
                             input logic [47:0] db, input logic eb);
        for (int i = 0; i < 6; i++) drive(i == 0, da[47-8*i -: 8]);
        @(negedge clk);
        chk("R8", "overlap first valid", dec_valid, 1'b1);
        chk("R9", "overlap first verdict", dec_accept, ea);
        in_valid = 1'b1; in_sof = 1'b1; in_data = db[47:40];
        for (int i = 1; i < 6; i++) drive(1'b0, db[47-8*i -: 8]);
        @(negedge clk);
        chk("R8", "overlap second valid", dec_valid, 1'b1);
        chk("R9", "overlap second verdict", dec_accept, eb);
        idle();
    endtask

    task automatic t_sample_point();
        set_cfg(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) drive(i == 0, 8'hFF);
        drive(1'b0, 8'hFF);
        cfg_rx_en = 1'b1;
        @(negedge clk);
        chk("R10", "enable at sixth byte", dec_accept, 1'b1);
        cfg_rx_en = 1'b0;
        idle();
        cfg_rx_en = 1'b1;
        for (int i = 0; i < 5; i++) drive(i == 0, 8'hFF);
        drive(1'b0, 8'hFF);
        cfg_rx_en = 1'b0;
        @(negedge clk);
        chk("R10", "disable at sixth byte", dec_accept, 1'b0);
        cfg_rx_en = 1'b1;
        idle();
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_data = '0;
        set_cfg(1'b0, 1'b0, 1'b0);
        cfg_station = {16'h4E5F, 16'h2C3D, 16'h0A1B};
        cfg_hash = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", "reset dec_valid", dec_valid, 1'b0);
        chk("R8", "reset dec_accept", dec_accept, 1'b0);
        t_disabled();
        t_promisc();
        t_exact();
        t_bcast();
        t_hash();
        t_trailing();
        t_short();
        set_cfg(1'b1, 1'b0, 1'b0);
        t_overlap(BCAST, 1'b1, OTHER, 1'b0);
        t_overlap(OTHER, 1'b0, STN, 1'b1);
        t_sample_point();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule